// File: doc/BRIEF.md
# Linear-count display timing engine

This block generates the sync and data-enable timing for a video display output. One counter runs from the first pixel clock of each frame's vertical sync pulse to the end of the frame. Every vertical quantity (frame length, vsync length, start and end of the visible region) is compared against that counter as an absolute number of pixel clocks. A second counter, reset at every frame start, gives the position within the current line. Because the vertical window is linear, the picture can begin or end partway through a line. The embedded-panel variant uses this to start and end exactly on visible pixels.

Software programs the engine through a write-only register port. Every write lands in a staging copy. The whole staging copy, including the run bit, is transferred into the live copy together at a frame boundary, so a frame never mixes old and new settings. While the engine is inside the visible window it forwards the upstream pixel. If the upstream has no valid pixel, it sends a programmable underflow colour. Outside the window it sends a border colour. Line and frame counters are output for monitoring. A build parameter selects a generic output, a serial-panel output that always uses active-high sync, or an embedded-panel output that trims the vertical window by the horizontal porches.

Top module: `lin_timing_gen`

## Requirements
- R1: After reset the engine is idle. Sync, data-enable, pixel output, line count and frame count are all 0. The underflow colour (register 9) resets to 0xFF and the border colour (register 8) resets to 0.
- R2: The line position counts pixel clocks from 0 and returns to 0 after htotal clocks and at every frame start. htotal is register 0 bits [11:0]. hsync is active while the line position is less than the pulse width, which is register 0 bits [27:16].
- R3: The linear count runs from 0 to period−1 and then restarts. The period is register 1. vsync is active while the linear count is less than the length in register 2.
- R4: Data-enable is high when both conditions hold, inclusive at each end. The line position must lie in [first, last]; first is register 3 bits [11:0] and last is register 3 bits [27:16]. The linear count must lie in [vstart+skew, vend+skew], with vstart in register 4, vend in register 5 and skew in register 7.
- R5: A secondary window is held in registers 12, 13 and 14. Register 12 uses the same horizontal fields as register 3, and registers 13 and 14 give the linear first and last counts. When all three are zero they have no effect. Otherwise data-enable also requires the position to lie inside the secondary window.
- R6: The pixel output depends on the state. When data-enable is high and pix_valid is high, the output is pix_in. When data-enable is high and pix_valid is low, the output is the underflow colour. While running outside data-enable, the output is the border colour. While idle, the output is 0.
- R7: Register 6 bit 0 makes hsync active low and bit 1 makes vsync active low. While idle, each output rests at its inactive level. With IF_KIND = IFK_SERIAL both bits are ignored and sync is always active high.
- R8: With IF_KIND = IFK_EMBED the vertical window changes. Its start is vstart + first, and its end is vend − (htotal − 1 − last).
- R9: Register 11 bit 0 is the run bit. Suppose a write setting it is captured at edge E while the engine is idle. Then the first frame begins at edge E+1, and the linear count is 0 in the following cycle. If the bit is cleared, the current frame completes. The engine goes idle at the edge that ends linear count period−1.
- R10: Writes take effect only at the next frame start, and all of them together at that moment.
- R11: Register 10 bit 0 enables the frame counter and bit 1 enables the line counter. The frame counter increments at the end of each frame. The line counter increments at each line wrap and is cleared at every frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 4 | Register select |
| wr_data | input | 32 | Register write data |
| pix_in | input | 24 | Upstream pixel |
| pix_valid | input | 1 | Upstream pixel is valid this clock |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| de_o | output | 1 | Data-enable |
| pix_o | output | 24 | Outgoing pixel colour |
| line_cnt_o | output | 16 | Line counter |
| frame_cnt_o | output | 32 | Frame counter |

## Verification
The bench builds three copies of the engine that share one stimulus: the generic variant, IFK_SERIAL and IFK_EMBED, all with default widths. This lets one frame show the generic and the trimmed embedded window side by side. The same stimulus shows active-low polarity on the generic copy while the serial copy keeps active-high sync. A 10-clock line and a 40-clock frame keep each frame short. With a vertical start of 15, the window opens mid-line, so the linear comparison, the skew offset and the secondary window can all be reached within a few frames.

// File: rtl/lintg_pkg.sv
package lintg_pkg;
   localparam int HW = 12;  // line position width
   localparam int LW = 24;  // linear frame count width
   localparam int CW = 24;  // colour width
   localparam int DW = 32;  // register data width
   localparam int HF = 16;  // offset of the upper field in horizontal words

   typedef enum logic [3:0] {
      SEL_HPER   = 4'd0,
      SEL_FPER   = 4'd1,
      SEL_VLEN   = 4'd2,
      SEL_HWIN   = 4'd3,
      SEL_VBEG   = 4'd4,
      SEL_VFIN   = 4'd5,
      SEL_POLAR  = 4'd6,
      SEL_SKEW   = 4'd7,
      SEL_BORDER = 4'd8,
      SEL_UFLOW  = 4'd9,
      SEL_CNTCTL = 4'd10,
      SEL_RUN    = 4'd11,
      SEL_AHWIN  = 4'd12,
      SEL_AVBEG  = 4'd13,
      SEL_AVFIN  = 4'd14
   } reg_sel_e;

   typedef enum logic [1:0] {
      IFK_GENERIC = 2'd0,
      IFK_SERIAL  = 2'd1,
      IFK_EMBED   = 2'd2
   } if_kind_e;

   typedef struct packed {
      logic [HW-1:0] htotal;
      logic [HW-1:0] hpulse;
      logic [HW-1:0] hbeg;
      logic [HW-1:0] hend;
      logic [HW-1:0] ahbeg;
      logic [HW-1:0] ahend;
      logic [LW-1:0] fper;
      logic [LW-1:0] vlen;
      logic [LW-1:0] vbeg;
      logic [LW-1:0] vfin;
      logic [LW-1:0] skew;
      logic [LW-1:0] avbeg;
      logic [LW-1:0] avfin;
      logic          hs_low;
      logic          vs_low;
      logic          fcnt_en;
      logic          lcnt_en;
      logic [CW-1:0] border;
      logic [CW-1:0] uflow;
   } tcfg_t;

   function automatic tcfg_t cfg_default();
      tcfg_t c;
      c       = '0;
      c.uflow = CW'(8'hFF);
      return c;
   endfunction
endpackage

// File: rtl/lintg_regs.sv
module lintg_regs
   import lintg_pkg::*;
(
   input  logic          clk,
   input  logic          rst,
   input  logic          wr_en,
   input  logic [3:0]    wr_sel,
   input  logic [DW-1:0] wr_data,
   input  logic          load,
   output tcfg_t         cfg,
   output logic          stage_run
);
   tcfg_t stage;

   always_ff @(posedge clk) begin
      if (rst) begin
         stage     <= cfg_default();
         cfg       <= cfg_default();
         stage_run <= 1'b0;
      end else begin
         if (wr_en) begin
            case (wr_sel)
               SEL_HPER: begin
                  stage.htotal <= wr_data[HW-1:0];
                  stage.hpulse <= wr_data[HF +: HW];
               end
               SEL_FPER:   stage.fper <= wr_data[LW-1:0];
               SEL_VLEN:   stage.vlen <= wr_data[LW-1:0];
               SEL_HWIN: begin
                  stage.hbeg <= wr_data[HW-1:0];
                  stage.hend <= wr_data[HF +: HW];
               end
               SEL_VBEG:   stage.vbeg <= wr_data[LW-1:0];
               SEL_VFIN:   stage.vfin <= wr_data[LW-1:0];
               SEL_POLAR: begin
                  stage.hs_low <= wr_data[0];
                  stage.vs_low <= wr_data[1];
               end
               SEL_SKEW:   stage.skew   <= wr_data[LW-1:0];
               SEL_BORDER: stage.border <= wr_data[CW-1:0];
               SEL_UFLOW:  stage.uflow  <= wr_data[CW-1:0];
               SEL_CNTCTL: begin
                  stage.fcnt_en <= wr_data[0];
                  stage.lcnt_en <= wr_data[1];
               end
               SEL_RUN:    stage_run <= wr_data[0];
               SEL_AHWIN: begin
                  stage.ahbeg <= wr_data[HW-1:0];
                  stage.ahend <= wr_data[HF +: HW];
               end
               SEL_AVBEG:  stage.avbeg <= wr_data[LW-1:0];
               SEL_AVFIN:  stage.avfin <= wr_data[LW-1:0];
               default: ;
            endcase
         end
         if (load) cfg <= stage;
      end
   end

   logic unused_wd;
   assign unused_wd = ^wr_data;

   AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !load) |=> $stable(cfg)) else $error("live settings changed off a frame boundary"); // R10
endmodule

// File: rtl/lintg_scan.sv
module lintg_scan
   import lintg_pkg::*;
#(
   parameter int LINE_W  = 16,
   parameter int FRAME_W = 32
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               stage_run,
   input  logic [LW-1:0]      fper,
   input  logic [HW-1:0]      htotal,
   input  logic               fcnt_en,
   input  logic               lcnt_en,
   output logic               load,
   output logic               running,
   output logic [HW-1:0]      hpos,
   output logic [LW-1:0]      lin,
   output logic [LINE_W-1:0]  line_cnt,
   output logic [FRAME_W-1:0] frame_cnt
);
   logic [LW:0] lin_nx;
   logic [HW:0] hpos_nx;
   logic        frame_end;
   logic        line_end;

   assign lin_nx    = {1'b0, lin} + (LW+1)'(1);
   assign hpos_nx   = {1'b0, hpos} + (HW+1)'(1);
   assign frame_end = running && (lin_nx >= {1'b0, fper});
   assign line_end  = running && (hpos_nx >= {1'b0, htotal});
   assign load      = (!running && stage_run) || frame_end;

   always_ff @(posedge clk) begin
      if (rst) begin
         running   <= 1'b0;
         lin       <= '0;
         hpos      <= '0;
         line_cnt  <= '0;
         frame_cnt <= '0;
      end else begin
         if (load) begin
            running  <= stage_run;
            lin      <= '0;
            hpos     <= '0;
            line_cnt <= '0;
         end else if (running) begin
            lin  <= lin_nx[LW-1:0];
            hpos <= line_end ? '0 : hpos_nx[HW-1:0];
            if (line_end && lcnt_en) line_cnt <= line_cnt + LINE_W'(1);
         end
         if (frame_end && fcnt_en) frame_cnt <= frame_cnt + FRAME_W'(1);
      end
   end

   AST_LIN_RANGE: assert property (@(posedge clk) disable iff (rst)
      (running && fper != '0) |-> (lin < fper)) else $error("linear count past frame period"); // R3
   AST_HPOS_RANGE: assert property (@(posedge clk) disable iff (rst)
      (running && htotal != '0) |-> (hpos < htotal)) else $error("line position past htotal"); // R2
   AST_STOP_AT_FRAME: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $fell(running)) |-> $past(frame_end)) else $error("stopped mid-frame"); // R9
   AST_FRAME_STEP: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$stable(frame_cnt)) |-> (frame_cnt == FRAME_W'($past(frame_cnt) + FRAME_W'(1))))
      else $error("frame counter jumped"); // R11
endmodule

// File: rtl/lintg_win.sv
module lintg_win
   import lintg_pkg::*;
#(
   parameter if_kind_e IF_KIND = IFK_GENERIC
) (
   input  tcfg_t         cfg,
   input  logic          running,
   input  logic [HW-1:0] hpos,
   input  logic [LW-1:0] lin,
   input  logic [CW-1:0] pix_in,
   input  logic          pix_valid,
   output logic          hsync_o,
   output logic          vsync_o,
   output logic          de_o,
   output logic [CW-1:0] pix_o
);
   logic [LW-1:0] v_lo, v_hi;
   logic [LW:0]   lo_s, hi_s;
   logic          pol_h, pol_v;
   logic          hs_act, vs_act, h_in, v_in, a_in, act_used;

   if (IF_KIND == IFK_EMBED) begin : g_emb
      logic [HW-1:0] hfp;
      assign hfp  = cfg.htotal - cfg.hend - HW'(1);
      assign v_lo = cfg.vbeg + LW'(cfg.hbeg);
      assign v_hi = cfg.vfin - LW'(hfp);
   end else begin : g_plain
      assign v_lo = cfg.vbeg;
      assign v_hi = cfg.vfin;
   end

   if (IF_KIND == IFK_SERIAL) begin : g_hi_only
      assign pol_h = 1'b0;
      assign pol_v = 1'b0;
   end else begin : g_pol
      assign pol_h = cfg.hs_low;
      assign pol_v = cfg.vs_low;
   end

   assign lo_s     = {1'b0, v_lo} + {1'b0, cfg.skew};
   assign hi_s     = {1'b0, v_hi} + {1'b0, cfg.skew};
   assign hs_act   = running && (hpos < cfg.hpulse);
   assign vs_act   = running && (lin < cfg.vlen);
   assign h_in     = (hpos >= cfg.hbeg) && (hpos <= cfg.hend);
   assign v_in     = ({1'b0, lin} >= lo_s) && ({1'b0, lin} <= hi_s);
   assign act_used = |{cfg.ahbeg, cfg.ahend, cfg.avbeg, cfg.avfin};
   assign a_in     = (hpos >= cfg.ahbeg) && (hpos <= cfg.ahend) &&
                     (lin >= cfg.avbeg) && (lin <= cfg.avfin);

   assign de_o    = running && h_in && v_in && (!act_used || a_in);
   assign hsync_o = hs_act ^ pol_h;
   assign vsync_o = vs_act ^ pol_v;

   always_comb begin
      if (!running)      pix_o = '0;
      else if (!de_o)    pix_o = cfg.border;
      else if (pix_valid) pix_o = pix_in;
      else               pix_o = cfg.uflow;
   end

   logic unused_cfg;
   assign unused_cfg = ^{cfg.fper, cfg.fcnt_en, cfg.lcnt_en, cfg.htotal, cfg.hs_low, cfg.vs_low};
endmodule

// File: rtl/lin_timing_gen.sv
module lin_timing_gen
   import lintg_pkg::*;
#(
   parameter if_kind_e IF_KIND = IFK_GENERIC,
   parameter int       LINE_W  = 16,
   parameter int       FRAME_W = 32
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               wr_en,
   input  logic [3:0]         wr_sel,
   input  logic [DW-1:0]      wr_data,
   input  logic [CW-1:0]      pix_in,
   input  logic               pix_valid,
   output logic               hsync_o,
   output logic               vsync_o,
   output logic               de_o,
   output logic [CW-1:0]      pix_o,
   output logic [LINE_W-1:0]  line_cnt_o,
   output logic [FRAME_W-1:0] frame_cnt_o
);
   if (HW < 2 || HW > HF) begin : g_bad_hw
      $error("HW must lie in 2..HF");
   end
   if (LW > DW || CW > DW || HF + HW > DW) begin : g_bad_dw
      $error("fields do not fit the register word");
   end
   if (LINE_W < 1 || FRAME_W < 1) begin : g_bad_cnt
      $error("counter widths must be positive");
   end

   tcfg_t         cfg;
   logic          stage_run, load, running;
   logic [HW-1:0] hpos;
   logic [LW-1:0] lin;

   lintg_regs u_regs (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data),
      .load      (load),
      .cfg       (cfg),
      .stage_run (stage_run)
   );

   lintg_scan #(.LINE_W(LINE_W), .FRAME_W(FRAME_W)) u_scan (
      .clk       (clk),
      .rst       (rst),
      .stage_run (stage_run),
      .fper      (cfg.fper),
      .htotal    (cfg.htotal),
      .fcnt_en   (cfg.fcnt_en),
      .lcnt_en   (cfg.lcnt_en),
      .load      (load),
      .running   (running),
      .hpos      (hpos),
      .lin       (lin),
      .line_cnt  (line_cnt_o),
      .frame_cnt (frame_cnt_o)
   );

   lintg_win #(.IF_KIND(IF_KIND)) u_win (
      .cfg       (cfg),
      .running   (running),
      .hpos      (hpos),
      .lin       (lin),
      .pix_in    (pix_in),
      .pix_valid (pix_valid),
      .hsync_o   (hsync_o),
      .vsync_o   (vsync_o),
      .de_o      (de_o),
      .pix_o     (pix_o)
   );

   AST_DE_IDLE: assert property (@(posedge clk) disable iff (rst)
      !running |-> !de_o) else $error("data-enable while idle"); // R9
   AST_IDLE_BLANK: assert property (@(posedge clk) disable iff (rst)
      !running |-> (pix_o == '0)) else $error("pixel driven while idle"); // R6
   AST_UFLOW_FILL: assert property (@(posedge clk) disable iff (rst)
      (de_o && !pix_valid) |-> (pix_o == cfg.uflow)) else $error("missing underflow fill"); // R6
endmodule

// File: tb/lin_timing_gen_tb_top.sv
module lin_timing_gen_tb_top;
   import lintg_pkg::*;
   timeunit 1ns;
   timeprecision 1ps;

   localparam logic [CW-1:0] PIX    = 24'h123456;
   localparam logic [CW-1:0] BORDER = 24'h00AA00;
   localparam int N_VEC = 16;
   localparam int WD    = 200000;
   // linear count within the first frames, expected {hsync, vsync, de, de of embedded copy}
   localparam int VEC_LIN [N_VEC] = '{0, 1, 2, 9, 10, 14, 15, 18, 19, 20, 23, 27, 28, 33, 39, 40};
   localparam logic [3:0] VEC_EXP [N_VEC] = '{
      4'b1100, 4'b1100, 4'b0100, 4'b0100, 4'b1000, 4'b0000, 4'b0010, 4'b0011,
      4'b0000, 4'b1000, 4'b0011, 4'b0010, 4'b0000, 4'b0000, 4'b0000, 4'b1100};

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic          rst, wr_en, pix_valid;
   logic [3:0]    wr_sel;
   logic [DW-1:0] wr_data;
   logic [CW-1:0] pix_in;

   logic hs_a, vs_a, de_a, hs_s, vs_s, de_s, hs_e, vs_e, de_e;
   logic [CW-1:0] pix_a, pix_s, pix_e;
   logic [15:0]   ln_a, ln_s, ln_e;
   logic [31:0]   fr_a, fr_s, fr_e;

   lin_timing_gen dut_i (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .pix_in(pix_in), .pix_valid(pix_valid), .hsync_o(hs_a), .vsync_o(vs_a),
      .de_o(de_a), .pix_o(pix_a), .line_cnt_o(ln_a), .frame_cnt_o(fr_a));

   lin_timing_gen #(.IF_KIND(IFK_SERIAL)) dut_ser (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .pix_in(pix_in), .pix_valid(pix_valid), .hsync_o(hs_s), .vsync_o(vs_s),
      .de_o(de_s), .pix_o(pix_s), .line_cnt_o(ln_s), .frame_cnt_o(fr_s));

   lin_timing_gen #(.IF_KIND(IFK_EMBED)) dut_emb (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .pix_in(pix_in), .pix_valid(pix_valid), .hsync_o(hs_e), .vsync_o(vs_e),
      .de_o(de_e), .pix_o(pix_e), .line_cnt_o(ln_e), .frame_cnt_o(fr_e));

   int n_chk = 0;
   int n_err = 0;
   int lin_abs = 0;
   bit done = 1'b0;

   task automatic tick();
      @(posedge clk);
      #1;
      lin_abs++;
   endtask

   task automatic wr(input logic [3:0] sel, input logic [31:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic goto_abs(input int n);
      while (lin_abs < n) tick();
   endtask

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s at count %0d: actual %0h expected %0h", tag, lin_abs, act, exp);
      end
   endtask

   initial begin
      repeat (WD) @(posedge clk);
      if (!done) begin
         n_err++;
         $display("FAIL watchdog R9: run did not complete, actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      rst = 1'b1; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
      pix_in = PIX; pix_valid = 1'b1;
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      tick();
      // R1: idle after reset
      chk("R1 de", de_a, 0);
      chk("R1 hsync", hs_a, 0);
      chk("R1 vsync", vs_a, 0);
      chk("R1 pixel", pix_a, 0);
      chk("R1 line", ln_a, 0);
      chk("R1 frame", fr_a, 0);

      wr(SEL_HPER,   (32'd2 << 16) | 32'd10);
      wr(SEL_FPER,   32'd40);
      wr(SEL_VLEN,   32'd10);
      wr(SEL_HWIN,   (32'd8 << 16) | 32'd3);
      wr(SEL_VBEG,   32'd15);
      wr(SEL_VFIN,   32'd27);
      wr(SEL_BORDER, 32'(BORDER));
      wr(SEL_CNTCTL, 32'd3);
      // R9: settings alone do not start the engine
      chk("R9 idle de", de_a, 0);
      chk("R9 idle hsync", hs_a, 0);
      chk("R9 idle pixel", pix_a, 0);

      wr(SEL_RUN, 32'd1);
      tick();
      lin_abs = 0;

      for (int i = 0; i < N_VEC; i++) begin
         goto_abs(VEC_LIN[i]);
         chk("R2 hsync", hs_a, VEC_EXP[i][3]);
         chk("R3 vsync", vs_a, VEC_EXP[i][2]);
         chk("R4 de", de_a, VEC_EXP[i][1]);
         chk("R6 pixel", pix_a, VEC_EXP[i][1] ? PIX : BORDER);
         chk("R8 embedded de", de_e, VEC_EXP[i][0]);
      end

      // R1 + R6: default underflow colour inside the window
      goto_abs(63);
      pix_valid = 1'b0;
      #1 chk("R6 underflow", pix_a, 32'hFF);
      pix_valid = 1'b1;

      goto_abs(65);
      chk("R11 line", ln_a, 2);
      chk("R11 frame", fr_a, 1);

      wr(SEL_POLAR, 32'd3);
      goto_abs(70);
      chk("R10 polarity deferred", hs_a, 1);
      goto_abs(80);
      chk("R7 hsync low", hs_a, 0);
      chk("R7 vsync low", vs_a, 0);
      chk("R7 serial hsync", hs_s, 1);
      chk("R7 serial vsync", vs_s, 1);
      chk("R11 line cleared", ln_a, 0);
      goto_abs(82);
      chk("R7 hsync idle level", hs_a, 1);

      wr(SEL_POLAR, 32'd0);
      wr(SEL_SKEW, 32'd2);
      goto_abs(120);
      chk("R7 polarity restored", hs_a, 1);
      goto_abs(135);
      chk("R4 skew before", de_a, 0);
      goto_abs(137);
      chk("R4 skew start", de_a, 1);
      goto_abs(148);
      chk("R4 skew end", de_a, 1);

      goto_abs(150);
      wr(SEL_SKEW, 32'd0);
      wr(SEL_AHWIN, (32'd5 << 16) | 32'd4);
      wr(SEL_AVFIN, 32'd39);
      goto_abs(175);
      chk("R5 inside active", de_a, 1);
      goto_abs(178);
      chk("R5 outside active", de_a, 0);
      chk("R5 border", pix_a, 32'(BORDER));
      goto_abs(184);
      chk("R5 inside again", de_a, 1);

      goto_abs(186);
      wr(SEL_RUN, 32'd0);
      goto_abs(190);
      chk("R9 frame continues", hs_a, 1);
      goto_abs(199);
      chk("R11 frame count", fr_a, 4);
      tick();
      chk("R9 stopped de", de_a, 0);
      chk("R9 stopped hsync", hs_a, 0);
      chk("R9 stopped vsync", vs_a, 0);
      chk("R6 idle pixel", pix_a, 0);
      chk("R11 final frame", fr_a, 5);
      repeat (50) tick();
      chk("R9 stays idle", hs_a, 0);
      chk("R11 frame held", fr_a, 5);
      chk("R11 line held", ln_a, 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule